// File: doc/BRIEF.md
# Reorder Buffer with Operand Capture

This block holds in-flight instructions in a circular queue so that they finish out of order but leave in program order. A new instruction enters at the tail. Its slot number is its tag. Each of its two source operands arrives either as a ready value or as the tag of the older slot that will produce it.

An execution unit takes the oldest slot whose operands are both present and whose result is still missing. The unit names the slot by index and writes the result back through the execute port. That same write is also a result bus. Every slot, including one being inserted in that cycle, compares its waiting source tags with the written index and takes the value on a match.

The slot at the head leaves when its result is present and the consumer accepts it. If that head result carries an exception flag, the whole queue is discarded in one cycle instead.

Top module: `rob_core`

## Requirements
- R1: After reset `empty` is 1, `full` is 0, `disp_ready` is 1, and `ret_valid` and `issue_valid` are 0.
- R2: A dispatch accepted while `disp_ready` is 1 takes the slot number shown on `disp_idx`. Slots leave the head strictly in dispatch order, and `ret_idx` shows the leaving slot.
- R3: Once 8 instructions are held without any retiring, `full` is 1 and `disp_ready` is 0. Further dispatch requests are ignored: the count of later retirements equals only the accepted dispatches.
- R4: An execute write (`exec_valid` with `exec_idx` naming a held slot) stores `exec_value` and `exec_exc` in that slot and marks its result present one cycle later. `ret_valid` is 1 exactly when the buffer is not empty and the head result is present.
- R5: On an execute write, every held slot whose source is not yet present and whose source tag equals `exec_idx` takes `exec_value` for that source. A retired value therefore equals in-order execution of the dispatched stream.
- R6: A dispatch in the same cycle as an execute write captures the written value into any of its sources that are marked not present and whose tag equals `exec_idx`.
- R7: `issue_valid` is 1 when some held slot has both sources present and no result. `issue_idx` then names the first such slot counting from the head. `issue_op`, `issue_src1` and `issue_src2` show that slot's stored operation code and operand values.
- R8: When the head retires (`ret_valid` and `retire_ready`) with its exception flag set, `ret_exc` is 1 in that cycle and the buffer is empty in the next cycle. None of the younger slots ever retires.
- R9: `full` is 1 exactly when 8 slots are held, `empty` is 1 exactly when none is held, and `disp_ready` is the inverse of `full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | 2 | Operation code stored with the instruction |
| disp_dest | input | 3 | Destination register number |
| disp_src1_ok | input | 1 | First source value is present |
| disp_src1_tag | input | 3 | Producer slot of first source when not present |
| disp_src1_val | input | 16 | First source value when present |
| disp_src2_ok | input | 1 | Second source value is present |
| disp_src2_tag | input | 3 | Producer slot of second source when not present |
| disp_src2_val | input | 16 | Second source value when present |
| disp_ready | output | 1 | Dispatch will be accepted |
| disp_idx | output | 3 | Slot (tag) a dispatch in this cycle receives |
| exec_valid | input | 1 | Execute result write |
| exec_idx | input | 3 | Slot that produced the result |
| exec_value | input | 16 | Result value |
| exec_exc | input | 1 | Result raises an exception |
| issue_valid | output | 1 | A slot is ready to execute |
| issue_idx | output | 3 | Oldest ready slot |
| issue_op | output | 2 | Operation code of that slot |
| issue_src1 | output | 16 | First operand of that slot |
| issue_src2 | output | 16 | Second operand of that slot |
| retire_ready | input | 1 | Consumer accepts the head |
| ret_valid | output | 1 | Head result is present |
| ret_idx | output | 3 | Head slot number |
| ret_dest | output | 3 | Head destination register |
| ret_value | output | 16 | Head result value |
| ret_exc | output | 1 | Head result carries an exception |
| full | output | 1 | All slots held |
| empty | output | 1 | No slot held |

## Verification
The bench uses the package defaults: 8 slots with 4-bit head and tail pointers, eight destination registers and 16-bit data. With only eight registers, random streams reuse registers constantly. Most instructions therefore wait on an older slot, and a producer often completes in the very cycle its consumer is dispatched. The pointers wrap past the slot count many times, and a fill phase drives the buffer full while dispatch keeps being requested. Exceptions arise on roughly one in eight checked-add results, so flushes occur at all fill levels and are followed by fresh streams that restart from committed register values.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int unsigned IDX_W  = 3;
    localparam int unsigned DEPTH  = 1 << IDX_W;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned REG_W  = 3;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [IDX_W:0]    ptr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [REG_W-1:0]  reg_t;

    typedef enum logic [1:0] {
        OP_ADD    = 2'd0,
        OP_SUB    = 2'd1,
        OP_XOR    = 2'd2,
        OP_ADDCHK = 2'd3
    } op_e;

    // one source operand: present flag, producer tag, captured value
    typedef struct packed {
        logic  ok;
        idx_t  tag;
        data_t val;
    } src_t;

    typedef struct packed {
        op_e  op;
        reg_t dest;
        src_t s1;
        src_t s2;
    } disp_t;

    typedef struct packed {
        logic  done;
        logic  exc;
        data_t value;
        op_e   op;
        reg_t  dest;
        src_t  s1;
        src_t  s2;
    } entry_t;

    // what the rest of the buffer sees of a slot
    typedef struct packed {
        logic  done;
        logic  exc;
        data_t value;
        op_e   op;
        reg_t  dest;
        logic  a_ok;
        data_t a_val;
        logic  b_ok;
        data_t b_val;
    } view_t;

    // result-bus snoop of one waiting source
    function automatic src_t snoop(input src_t s, input logic hit_v,
                                   input idx_t hit_tag, input data_t hit_val);
        src_t r;
        r = s;
        if (!s.ok && hit_v && (s.tag == hit_tag)) begin
            r.ok  = 1'b1;
            r.val = hit_val;
        end
        return r;
    endfunction

endpackage

// File: rtl/rob_ptr.sv
module rob_ptr import rob_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output idx_t             head_idx,
    output idx_t             tail_idx,
    output logic             full,
    output logic             empty,
    output logic [DEPTH-1:0] occ
);
    localparam ptr_t DEPTH_P = ptr_t'(DEPTH);

    ptr_t head_q;
    ptr_t tail_q;
    ptr_t fill;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (flush) begin
            head_q <= tail_q;
        end else begin
            if (pop)  head_q <= head_q + ptr_t'(1);
            if (push) tail_q <= tail_q + ptr_t'(1);
        end
    end

    assign fill     = tail_q - head_q;
    assign full     = (fill == DEPTH_P);
    assign empty    = (fill == '0);
    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];

    for (genvar i = 0; i < DEPTH; i++) begin : g_occ
        idx_t off;
        assign off    = idx_t'(i) - head_idx;
        assign occ[i] = ptr_t'(off) < fill;
    end

    assert_fill_bound_R9: assert property (@(posedge clk) disable iff (rst)
        fill <= DEPTH_P);

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (full && !pop && !flush) |=> full);

endmodule

// File: rtl/rob_slot.sv
module rob_slot import rob_pkg::*; #(
    parameter idx_t SLOT = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  alloc,
    input  disp_t din,
    input  logic  bc_fire,
    input  idx_t  bc_tag,
    input  data_t bc_val,
    input  logic  bc_exc,
    output view_t view
);
    entry_t q;
    logic   wr;

    assign wr = bc_fire && (bc_tag == SLOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (flush) begin
            q.done  <= 1'b0;
            q.exc   <= 1'b0;
            q.s1.ok <= 1'b0;
            q.s2.ok <= 1'b0;
        end else if (alloc) begin
            q.done  <= 1'b0;
            q.exc   <= 1'b0;
            q.value <= '0;
            q.op    <= din.op;
            q.dest  <= din.dest;
            q.s1    <= snoop(din.s1, bc_fire, bc_tag, bc_val);
            q.s2    <= snoop(din.s2, bc_fire, bc_tag, bc_val);
        end else begin
            if (wr) begin
                q.done  <= 1'b1;
                q.value <= bc_val;
                q.exc   <= bc_exc;
            end
            q.s1 <= snoop(q.s1, bc_fire, bc_tag, bc_val);
            q.s2 <= snoop(q.s2, bc_fire, bc_tag, bc_val);
        end
    end

    assign view = '{done: q.done, exc: q.exc, value: q.value, op: q.op,
                    dest: q.dest, a_ok: q.s1.ok, a_val: q.s1.val,
                    b_ok: q.s2.ok, b_val: q.s2.val};

    // R5: a waiting source picks up the bus value and keeps it afterwards
    assert_capture_src1_R5: assert property (@(posedge clk) disable iff (rst)
        (!flush && !alloc && bc_fire && !q.s1.ok && (q.s1.tag == bc_tag))
        |=> (q.s1.ok && (q.s1.val == $past(bc_val))));

    assert_hold_src2_R5: assert property (@(posedge clk) disable iff (rst)
        (!flush && !alloc && q.s2.ok) |=> (q.s2.ok && $stable(q.s2.val)));

    // R6: same-cycle capture on insertion
    assert_bypass_src1_R6: assert property (@(posedge clk) disable iff (rst)
        (!flush && alloc && bc_fire && !din.s1.ok && (din.s1.tag == bc_tag))
        |=> (q.s1.ok && (q.s1.val == $past(bc_val))));

endmodule

// File: rtl/rob_pick.sv
module rob_pick import rob_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  idx_t             head_idx,
    input  logic [DEPTH-1:0] rdy,
    output logic             found,
    output idx_t             pick
);
    // age-ordered scan starting at the head slot
    always_comb begin
        found = 1'b0;
        pick  = head_idx;
        for (int k = 0; k < DEPTH; k++) begin
            if (!found && rdy[head_idx + idx_t'(k)]) begin
                found = 1'b1;
                pick  = head_idx + idx_t'(k);
            end
        end
    end

    assert_pick_ready_R7: assert property (@(posedge clk) disable iff (rst)
        found |-> rdy[pick]);

    assert_idle_when_none_R7: assert property (@(posedge clk) disable iff (rst)
        (rdy == '0) |-> !found);

    assert_head_first_R7: assert property (@(posedge clk) disable iff (rst)
        rdy[head_idx] |-> (pick == head_idx));

endmodule

// File: rtl/rob_core.sv
module rob_core import rob_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_valid,
    input  logic [1:0]        disp_op,
    input  logic [REG_W-1:0]  disp_dest,
    input  logic              disp_src1_ok,
    input  logic [IDX_W-1:0]  disp_src1_tag,
    input  logic [DATA_W-1:0] disp_src1_val,
    input  logic              disp_src2_ok,
    input  logic [IDX_W-1:0]  disp_src2_tag,
    input  logic [DATA_W-1:0] disp_src2_val,
    output logic              disp_ready,
    output logic [IDX_W-1:0]  disp_idx,
    input  logic              exec_valid,
    input  logic [IDX_W-1:0]  exec_idx,
    input  logic [DATA_W-1:0] exec_value,
    input  logic              exec_exc,
    output logic              issue_valid,
    output logic [IDX_W-1:0]  issue_idx,
    output logic [1:0]        issue_op,
    output logic [DATA_W-1:0] issue_src1,
    output logic [DATA_W-1:0] issue_src2,
    input  logic              retire_ready,
    output logic              ret_valid,
    output logic [IDX_W-1:0]  ret_idx,
    output logic [REG_W-1:0]  ret_dest,
    output logic [DATA_W-1:0] ret_value,
    output logic              ret_exc,
    output logic              full,
    output logic              empty
);
    idx_t             head_idx;
    idx_t             tail_idx;
    logic [DEPTH-1:0] occ;
    logic [DEPTH-1:0] rdy_vec;
    logic [DEPTH-1:0] done_vec;
    view_t            views [DEPTH];
    disp_t            din;
    idx_t             pick;
    logic             found;
    logic             push;
    logic             pop;
    logic             flush;
    logic             ret_fire;
    logic             exec_fire;

    assign din = '{op: op_e'(disp_op), dest: disp_dest,
                   s1: '{ok: disp_src1_ok, tag: disp_src1_tag, val: disp_src1_val},
                   s2: '{ok: disp_src2_ok, tag: disp_src2_tag, val: disp_src2_val}};

    assign ret_valid = !empty && views[head_idx].done;
    assign ret_fire  = ret_valid && retire_ready;
    assign flush     = ret_fire && views[head_idx].exc;
    assign pop       = ret_fire && !flush;
    assign push      = disp_valid && !full && !flush;
    assign exec_fire = exec_valid && occ[exec_idx] && !flush;

    rob_ptr u_ptr (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .flush    (flush),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .full     (full),
        .empty    (empty),
        .occ      (occ)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rob_slot #(.SLOT(idx_t'(i))) u_slot (
            .clk     (clk),
            .rst     (rst),
            .flush   (flush),
            .alloc   (push && (tail_idx == idx_t'(i))),
            .din     (din),
            .bc_fire (exec_fire),
            .bc_tag  (exec_idx),
            .bc_val  (exec_value),
            .bc_exc  (exec_exc),
            .view    (views[i])
        );
        assign done_vec[i] = views[i].done;
        assign rdy_vec[i]  = occ[i] && views[i].a_ok && views[i].b_ok && !views[i].done;
    end

    rob_pick u_pick (
        .clk      (clk),
        .rst      (rst),
        .head_idx (head_idx),
        .rdy      (rdy_vec),
        .found    (found),
        .pick     (pick)
    );

    assign disp_ready  = !full;
    assign disp_idx    = tail_idx;
    assign issue_valid = found;
    assign issue_idx   = pick;
    assign issue_op    = views[pick].op;
    assign issue_src1  = views[pick].a_val;
    assign issue_src2  = views[pick].b_val;
    assign ret_idx     = head_idx;
    assign ret_dest    = views[head_idx].dest;
    assign ret_value   = views[head_idx].value;
    assign ret_exc     = ret_valid && views[head_idx].exc;

    assert_exec_marks_done_R4: assert property (@(posedge clk) disable iff (rst)
        exec_fire |=> done_vec[$past(exec_idx)]);

    assert_retire_in_order_R2: assert property (@(posedge clk) disable iff (rst)
        (ret_fire && !flush) |=> (head_idx == idx_t'($past(head_idx) + idx_t'(1))));

    assert_full_refuses_R3: assert property (@(posedge clk) disable iff (rst)
        full |=> (tail_idx == $past(tail_idx)));

    assert_flush_drops_all_R8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!ret_valid && !issue_valid));

endmodule

// File: tb/rob_core_bench.sv
module rob_core_bench;
    import rob_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 1 << REG_W;
    localparam int WATCH      = 100000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              disp_valid = 1'b0;
    logic [1:0]        disp_op = '0;
    logic [REG_W-1:0]  disp_dest = '0;
    logic              disp_src1_ok = 1'b0;
    logic [IDX_W-1:0]  disp_src1_tag = '0;
    logic [DATA_W-1:0] disp_src1_val = '0;
    logic              disp_src2_ok = 1'b0;
    logic [IDX_W-1:0]  disp_src2_tag = '0;
    logic [DATA_W-1:0] disp_src2_val = '0;
    logic              disp_ready;
    logic [IDX_W-1:0]  disp_idx;
    logic              exec_valid = 1'b0;
    logic [IDX_W-1:0]  exec_idx = '0;
    logic [DATA_W-1:0] exec_value = '0;
    logic              exec_exc = 1'b0;
    logic              issue_valid;
    logic [IDX_W-1:0]  issue_idx;
    logic [1:0]        issue_op;
    logic [DATA_W-1:0] issue_src1;
    logic [DATA_W-1:0] issue_src2;
    logic              retire_ready = 1'b0;
    logic              ret_valid;
    logic [IDX_W-1:0]  ret_idx;
    logic [REG_W-1:0]  ret_dest;
    logic [DATA_W-1:0] ret_value;
    logic              ret_exc;
    logic              full;
    logic              empty;

    always #(CLK_PERIOD/2) clk = ~clk;

    rob_core u_rob_core (.*);

    typedef struct {
        int idx; int op; int dest; int s1r; int s2r;
        bit s1ok; bit s2ok; int s1tag; int s2tag; bit done;
    } ment_t;

    ment_t q[$];
    bit    pend [NREG];
    int    rtag [NREG];
    data_t rval [NREG];
    data_t arch [NREG];

    int total = 0, fails = 0;
    int p_disp = 0, p_exec = 0, p_ret = 0;
    int bypass_seen = 0, flushes = 0, retired = 0;
    bit flush_prev = 0;
    bit finished = 0;

    function automatic data_t alu(input int op, input data_t a, input data_t b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a ^ b;
            default: return a + b;
        endcase
    endfunction

    function automatic bit raises(input int op, input data_t r);
        return (op == 3) && (r[2:0] == 3'd0);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        bit exp_rv, fire, flushing, do_exec, do_disp, accept, vexc, fnd;
        int e, kf, op, dst, r1, r2;
        data_t a, b, r, v;
        bit x;
        ment_t m;

        if (flush_prev) chk(empty === 1'b1, "R8", "empty after flush", int'(empty), 1);
        flush_prev = 0;

        chk(full === (q.size() == DEPTH), "R9", "full", int'(full), int'(q.size() == DEPTH));
        chk(empty === (q.size() == 0), "R9", "empty", int'(empty), int'(q.size() == 0));
        chk(disp_ready === (q.size() != DEPTH), "R9", "disp_ready", int'(disp_ready),
            int'(q.size() != DEPTH));

        exp_rv = (q.size() > 0) && q[0].done;
        chk(ret_valid === exp_rv, "R4", "ret_valid", int'(ret_valid), int'(exp_rv));

        fnd = 0; kf = 0;
        for (int k = 0; k < q.size(); k++)
            if (!fnd && q[k].s1ok && q[k].s2ok && !q[k].done) begin fnd = 1; kf = k; end
        chk(issue_valid === fnd, "R7", "issue_valid", int'(issue_valid), int'(fnd));
        if (fnd && issue_valid)
            chk(int'(issue_idx) == q[kf].idx, "R7", "issue_idx", int'(issue_idx), q[kf].idx);

        disp_valid = 0; exec_valid = 0; exec_exc = 0;
        retire_ready = ($urandom_range(99) < p_ret);
        fire = retire_ready && ret_valid && exp_rv;
        flushing = 0;
        if (fire) begin
            a = arch[q[0].s1r]; b = arch[q[0].s2r];
            r = alu(q[0].op, a, b);
            x = raises(q[0].op, r);
            chk(int'(ret_idx) == q[0].idx, "R2", "ret_idx order", int'(ret_idx), q[0].idx);
            chk(int'(ret_dest) == q[0].dest, "R2", "ret_dest", int'(ret_dest), q[0].dest);
            if (!x)
                chk(ret_value === r, "R5/R6", "retired value", int'(ret_value), int'(r));
            chk(ret_exc === x, "R8", "ret_exc", int'(ret_exc), int'(x));
            if (x) flushing = 1;
            else arch[q[0].dest] = r;
            retired++;
        end

        do_exec = !flushing && issue_valid && ($urandom_range(99) < p_exec);
        e = 0; v = '0; vexc = 0;
        if (do_exec) begin
            e = int'(issue_idx);
            v = alu(int'(issue_op), issue_src1, issue_src2);
            vexc = raises(int'(issue_op), v);
            exec_valid = 1; exec_idx = issue_idx; exec_value = v; exec_exc = vexc;
        end

        do_disp = !flushing && ($urandom_range(99) < p_disp);
        accept = 0;
        op = 0; dst = 0; r1 = 0; r2 = 0;
        if (do_disp) begin
            op = $urandom_range(3); dst = $urandom_range(NREG-1);
            r1 = $urandom_range(NREG-1); r2 = $urandom_range(NREG-1);
            disp_valid = 1; disp_op = 2'(op); disp_dest = REG_W'(dst);
            disp_src1_ok = !pend[r1]; disp_src1_tag = IDX_W'(rtag[r1]); disp_src1_val = rval[r1];
            disp_src2_ok = !pend[r2]; disp_src2_tag = IDX_W'(rtag[r2]); disp_src2_val = rval[r2];
            accept = disp_ready;
        end

        if (fire) begin
            if (flushing) begin
                q.delete();
                for (int g = 0; g < NREG; g++) begin pend[g] = 0; rval[g] = arch[g]; end
                flushes++;
                flush_prev = 1;
            end else begin
                void'(q.pop_front());
            end
        end
        if (do_disp && accept) begin
            m.idx = int'(disp_idx); m.op = op; m.dest = dst; m.s1r = r1; m.s2r = r2;
            m.s1ok = !pend[r1]; m.s2ok = !pend[r2];
            m.s1tag = rtag[r1]; m.s2tag = rtag[r2]; m.done = 0;
            if (do_exec && ((pend[r1] && rtag[r1] == e) || (pend[r2] && rtag[r2] == e)))
                bypass_seen++;
            q.push_back(m);
            pend[dst] = 1; rtag[dst] = int'(disp_idx);
        end
        if (do_exec) begin
            for (int k = 0; k < q.size(); k++) begin
                if (q[k].idx == e) q[k].done = 1;
                if (!q[k].s1ok && q[k].s1tag == e) q[k].s1ok = 1;
                if (!q[k].s2ok && q[k].s2tag == e) q[k].s2ok = 1;
            end
            for (int g = 0; g < NREG; g++)
                if (pend[g] && rtag[g] == e) begin pend[g] = 0; rval[g] = v; end
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (WATCH) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL R2 watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        for (int g = 0; g < NREG; g++) begin
            arch[g] = data_t'(g * 37 + 11); rval[g] = arch[g]; pend[g] = 0; rtag[g] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(empty === 1'b1, "R1", "empty", int'(empty), 1);
        chk(full === 1'b0, "R1", "full", int'(full), 0);
        chk(disp_ready === 1'b1, "R1", "disp_ready", int'(disp_ready), 1);
        chk(ret_valid === 1'b0, "R1", "ret_valid", int'(ret_valid), 0);
        chk(issue_valid === 1'b0, "R1", "issue_valid", int'(issue_valid), 0);

        // R3 fill with dispatch kept requested past capacity
        p_disp = 100; p_exec = 0; p_ret = 0;
        repeat (DEPTH + 4) step();
        chk(full === 1'b1, "R3", "full after fill", int'(full), 1);
        chk(disp_ready === 1'b0, "R3", "disp_ready while full", int'(disp_ready), 0);
        chk(q.size() == DEPTH, "R3", "accepted count", q.size(), DEPTH);

        // drain: only accepted entries retire
        p_disp = 0; p_exec = 100; p_ret = 100;
        for (int n = 0; n < 200 && q.size() != 0; n++) step();
        step();
        chk(empty === 1'b1, "R3", "empty after drain", int'(empty), 1);
        chk(issue_valid === 1'b0, "R7", "no issue when empty", int'(issue_valid), 0);

        // random dependent streams
        p_disp = 60; p_exec = 50; p_ret = 60;
        repeat (4000) step();
        p_disp = 90; p_exec = 90; p_ret = 30;
        repeat (2000) step();
        p_disp = 80; p_exec = 100; p_ret = 100;
        repeat (1000) step();

        p_disp = 0; p_exec = 100; p_ret = 100;
        for (int n = 0; n < 200 && q.size() != 0; n++) step();
        step();
        chk(empty === 1'b1, "R9", "empty at end", int'(empty), 1);
        chk(bypass_seen > 0, "R6", "same-cycle captures seen", bypass_seen, 1);
        chk(flushes > 0, "R8", "flushes seen", flushes, 1);
        chk(retired > 100, "R2", "retirements", retired, 101);

        finished = 1;
        summary();
        $finish;
    end
endmodule